// File: doc/BRIEF.md
# Performance-Monitor Access Control Register Gate

This block guards one 64-bit system control register, which decides which performance counters user code may reach. Every read or write aimed at the register arrives as a request carrying the privilege level (0 to 3), the instruction encoding and, for writes, the data. The block also sees a set of static configuration inputs: feature-present flags, the trap and enable bits held by the level-2 and level-3 configuration registers, the level-2 fine-grained read and write trap bits, and the flags that control how secure debug disable affects the outcome.

The block arbitrates these inputs in a fixed priority order and returns one of four outcomes. The outcome is permitted, undefined instruction, trap to level 2 or trap to level 3. A trap also carries a 6-bit exception class. A permitted read returns the stored value. A permitted write updates the register. Requests with any other encoding get no response.

The outcome appears one cycle after the request. The exception entry that follows a trap is left to the surrounding core.

Top module: `pmu_uacr_gate`

## Requirements
- R1: If either the performance-monitor feature flag or the 64-bit execution feature flag is 0, every selected access is undefined, whatever the privilege level.
- R2: A selected access from level 0 is undefined.
- R3: At levels 1 and 2, if level 3 exists and the undef-priority flag is set, the access is undefined when the level-3 enable bit is 0 or the level-3 trap bit is 1. This check wins over every level-2 check.
- R4: At level 1, the fine-grained check applies when level 2 is enabled and the fine-grained feature exists. The access traps to level 2 when level 3 exists with its fine-grained enable at 0, or when the relevant fine-grained bit is 0. Reads use the read bit and writes use the write bit.
- R5: At level 1, if R4 did not fire and level 2 is enabled with its trap bit at 1, the access traps to level 2.
- R6: At levels 1 and 2, after the checks above, if level 3 exists and its enable bit is 0 or its trap bit is 1, the outcome depends on the secure-debug-disable flag. The access is undefined when the flag is 1 and traps to level 3 otherwise.
- R7: At level 2, the level-2 trap bit and the fine-grained inputs have no effect.
- R8: Accesses from level 3 are permitted whenever both feature flags are 1.
- R9: The register is selected by the encoding {op0,op1,CRn,CRm,op2} = 16'hC4F4. A request with any other encoding produces no response and does not change the register.
- R10: A response strobe lasts one cycle and comes exactly one cycle after each selected request. Outcome codes are 0 permitted, 1 undefined, 2 trap to level 2, 3 trap to level 3. The exception class is 0x18 on a trap and 0 otherwise.
- R11: A permitted read returns the stored value on the data output. Every other response returns zero data.
- R12: The stored value resets to zero. Only a permitted selected write updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_enc | input | 16 | Encoding {op0,op1,CRn,CRm,op2} |
| req_el | input | 2 | Requesting privilege level |
| req_wdata | input | 64 | Write data |
| feat_pmu | input | 1 | Performance-monitor version feature present |
| feat_aa64 | input | 1 | 64-bit execution feature present |
| feat_fgt2 | input | 1 | Second fine-grained trap feature present |
| has_el3 | input | 1 | Level 3 implemented |
| el2_enabled | input | 1 | Level 2 enabled |
| l3_enable | input | 1 | Level-3 monitor enable bit |
| l3_trap | input | 1 | Level-3 monitor trap bit |
| l3_fgt_en | input | 1 | Level-3 fine-grained enable bit |
| l2_trap | input | 1 | Level-2 monitor trap bit |
| fgt_rd_ok | input | 1 | Level-2 fine-grained read bit (0 traps) |
| fgt_wr_ok | input | 1 | Level-2 fine-grained write bit (0 traps) |
| sdd_undef_pri | input | 1 | Undef-priority flag for secure debug disable |
| sdd_undef | input | 1 | Secure debug disable turns level-3 traps into undefined |
| rsp_valid | output | 1 | Response strobe |
| rsp_outcome | output | 2 | Outcome code |
| rsp_ec | output | 6 | Exception class |
| rsp_rdata | output | 64 | Read data |

## Verification
The bench builds the block with its default parameters: 64-bit data, selecting encoding 16'hC4F4 and trap class 0x18. With these values the real encoding can be told apart from neighbouring ones, and the full register width is written and read back. A directed pass visits each priority step, including cases where a higher check hides a lower one. A randomized sweep then mixes privilege levels, control-bit combinations and stray encodings, and checks the stored value through level-3 reads.

// File: rtl/pmu_uacr_gate.sv
module pmu_uacr_gate #(
  parameter int          DATA_W  = 64,
  parameter logic [15:0] SEL_ENC = 16'hC4F4,
  parameter logic [5:0]  TRAP_EC = 6'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [15:0]       req_enc,
  input  logic [1:0]        req_el,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              feat_pmu,
  input  logic              feat_aa64,
  input  logic              feat_fgt2,
  input  logic              has_el3,
  input  logic              el2_enabled,
  input  logic              l3_enable,
  input  logic              l3_trap,
  input  logic              l3_fgt_en,
  input  logic              l2_trap,
  input  logic              fgt_rd_ok,
  input  logic              fgt_wr_ok,
  input  logic              sdd_undef_pri,
  input  logic              sdd_undef,
  output logic              rsp_valid,
  output logic [1:0]        rsp_outcome,
  output logic [5:0]        rsp_ec,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam logic [1:0] OUT_OK = 2'd0, OUT_UNDEF = 2'd1, OUT_EL2 = 2'd2, OUT_EL3 = 2'd3;

  logic [DATA_W-1:0] store_q;
  logic [1:0]        verdict;
  logic              hit, fgt_bit, l3_block, sdd_block;

  assign hit       = req_valid && (req_enc == SEL_ENC);
  assign fgt_bit   = req_write ? fgt_wr_ok : fgt_rd_ok;
  assign l3_block  = has_el3 && (!l3_enable || l3_trap);
  assign sdd_block = l3_block && sdd_undef_pri;

  always_comb begin
    verdict = OUT_OK;
    if (!(feat_pmu && feat_aa64))
      verdict = OUT_UNDEF;
    else if (req_el == 2'd0)
      verdict = OUT_UNDEF;
    else if (req_el != 2'd3) begin
      if (sdd_block)
        verdict = OUT_UNDEF;
      else if (req_el == 2'd1 && el2_enabled && feat_fgt2 &&
               ((has_el3 && !l3_fgt_en) || !fgt_bit))
        verdict = OUT_EL2;
      else if (req_el == 2'd1 && el2_enabled && l2_trap)
        verdict = OUT_EL2;
      else if (l3_block)
        verdict = sdd_undef ? OUT_UNDEF : OUT_EL3;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q     <= '0;
      rsp_valid   <= 1'b0;
      rsp_outcome <= OUT_OK;
      rsp_ec      <= '0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid   <= hit;
      rsp_outcome <= hit ? verdict : OUT_OK;
      rsp_ec      <= (hit && verdict[1]) ? TRAP_EC : '0;
      rsp_rdata   <= (hit && !req_write && verdict == OUT_OK) ? store_q : '0;
      if (hit && req_write && verdict == OUT_OK)
        store_q <= req_wdata;
    end
  end

  // R2
  el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && req_el == 2'd0 |=> rsp_valid && rsp_outcome == OUT_UNDEF);
  // R8
  el3_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && req_el == 2'd3 && feat_pmu && feat_aa64 |=> rsp_outcome == OUT_OK);
  // R9
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_enc != SEL_ENC |=> !rsp_valid);
  // R10
  trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_outcome[1] |-> rsp_ec == TRAP_EC);
  // R11
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_outcome != OUT_OK |-> rsp_rdata == '0);
  // R12
  store_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(store_q) |-> rsp_valid && rsp_outcome == OUT_OK && $past(req_write));
endmodule

// File: tb/pmu_uacr_gate_tb.sv
module pmu_uacr_gate_tb;
  localparam logic [15:0] ENC = 16'hC4F4;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_enc = 0;
  logic [1:0] req_el = 0;
  logic [63:0] req_wdata = 0;
  logic feat_pmu = 1, feat_aa64 = 1, feat_fgt2 = 1, has_el3 = 1, el2_enabled = 1;
  logic l3_enable = 1, l3_trap = 0, l3_fgt_en = 1, l2_trap = 0;
  logic fgt_rd_ok = 1, fgt_wr_ok = 1, sdd_undef_pri = 0, sdd_undef = 0;
  logic rsp_valid;
  logic [1:0] rsp_outcome;
  logic [5:0] rsp_ec;
  logic [63:0] rsp_rdata;

  int checks = 0, failures = 0;
  logic [71:0] exp_q[$];
  string tag_q[$];
  logic [63:0] model_reg = 0;

  always #5 clk = ~clk;

  pmu_uacr_gate u_dut (.*);

  function automatic logic [1:0] model(input logic wr, output string tag);
    logic fb;
    fb = wr ? fgt_wr_ok : fgt_rd_ok;
    if (!(feat_pmu && feat_aa64)) begin tag = "R1"; return 2'd1; end
    if (req_el == 0) begin tag = "R2"; return 2'd1; end
    if (req_el == 3) begin tag = "R8"; return 2'd0; end
    if (has_el3 && sdd_undef_pri && (!l3_enable || l3_trap)) begin tag = "R3"; return 2'd1; end
    if (req_el == 1 && el2_enabled && feat_fgt2 && ((has_el3 && !l3_fgt_en) || !fb)) begin
      tag = "R4"; return 2'd2;
    end
    if (req_el == 1 && el2_enabled && l2_trap) begin tag = "R5"; return 2'd2; end
    if (has_el3 && (!l3_enable || l3_trap)) begin tag = "R6"; return sdd_undef ? 2'd1 : 2'd3; end
    tag = (req_el == 2) ? "R7" : "R11";
    return 2'd0;
  endfunction

  task automatic issue(input logic [1:0] el, input logic wr, input logic [15:0] enc,
                       input logic [63:0] wd);
    logic [1:0] o;
    string t;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_enc = enc; req_el = el; req_wdata = wd;
    if (enc == ENC) begin
      o = model(wr, t);
      exp_q.push_back({o, (o[1] ? 6'h18 : 6'h00), ((!wr && o == 0) ? model_reg : 64'h0)});
      tag_q.push_back(t);
      if (wr && o == 0) model_reg = wd;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic baseline();
    feat_pmu = 1; feat_aa64 = 1; feat_fgt2 = 1; has_el3 = 1; el2_enabled = 1;
    l3_enable = 1; l3_trap = 0; l3_fgt_en = 1; l2_trap = 0;
    fgt_rd_ok = 1; fgt_wr_ok = 1; sdd_undef_pri = 0; sdd_undef = 0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && rsp_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R9 unexpected response outcome=%0d expected none", rsp_outcome);
        end else begin
          logic [71:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rsp_outcome !== e[71:70]) begin
            failures++;
            $display("FAIL %s outcome=%0d expected=%0d", t, rsp_outcome, e[71:70]);
          end
          checks++;
          if (rsp_ec !== e[69:64]) begin
            failures++;
            $display("FAIL R10 (%s) ec=%h expected=%h", t, rsp_ec, e[69:64]);
          end
          checks++;
          if (rsp_rdata !== e[63:0]) begin
            failures++;
            $display("FAIL R11/R12 (%s) rdata=%h expected=%h", t, rsp_rdata, e[63:0]);
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired, pending=%0d expected 0", exp_q.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;  // R12 reset state
    if (rsp_valid !== 0 || rsp_rdata !== 0) begin
      failures++;
      $display("FAIL R12 reset valid=%b rdata=%h expected 0/0", rsp_valid, rsp_rdata);
    end
    issue(3, 0, ENC, 0);                             // R12 reset value reads zero
    feat_pmu = 0; issue(3, 0, ENC, 0);               // R1
    baseline(); feat_aa64 = 0; issue(1, 1, ENC, 64'h1); // R1
    baseline(); issue(0, 0, ENC, 0);                 // R2
    sdd_undef_pri = 1; l3_enable = 0; l2_trap = 1; issue(1, 0, ENC, 0); // R3 over R5
    baseline(); sdd_undef_pri = 1; l3_trap = 1; issue(2, 1, ENC, 64'h2); // R3
    baseline(); fgt_rd_ok = 0; issue(1, 0, ENC, 0);  // R4 read bit
    issue(1, 1, ENC, 64'hA5A5_0000_1234_5678);       // R4 write bit clear of trap -> permit
    issue(3, 0, ENC, 0);                             // R11 readback
    baseline(); l3_fgt_en = 0; issue(1, 1, ENC, 64'h3); // R4 level-3 fine enable
    baseline(); l2_trap = 1; issue(1, 0, ENC, 0);    // R5
    baseline(); l3_trap = 1; sdd_undef = 1; issue(1, 0, ENC, 0); // R6 undefined
    sdd_undef = 0; issue(2, 0, ENC, 0);              // R6 trap to level 3
    baseline(); l2_trap = 1; fgt_rd_ok = 0; fgt_wr_ok = 0; l3_fgt_en = 0;
    issue(2, 1, ENC, 64'hFFFF_0000_FFFF_0000);       // R7
    issue(2, 0, ENC, 0);                             // R7 readback
    baseline(); issue(3, 1, 16'hC4F5, 64'hDEAD);     // R9 neighbour encoding ignored
    issue(3, 1, 16'h44F4, 64'hBEEF);                 // R9
    issue(3, 0, ENC, 0);                             // R9 value unchanged
    l2_trap = 1; issue(1, 1, ENC, 64'h77);           // R12 trapped write no effect
    baseline(); issue(3, 0, ENC, 0);                 // R12 readback
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      feat_pmu = r[0] | r[1]; feat_aa64 = r[2] | r[3]; feat_fgt2 = r[4];
      has_el3 = r[5]; el2_enabled = r[6]; l3_enable = r[7] | r[8]; l3_trap = r[9] & r[10];
      l3_fgt_en = r[11]; l2_trap = r[12] & r[13]; fgt_rd_ok = r[14]; fgt_wr_ok = r[15];
      sdd_undef_pri = r[16] & r[17]; sdd_undef = r[18];
      issue(r[20:19], r[21], (r[24:22] == 0) ? (ENC ^ 16'(1 << r[28:25])) : ENC,
            {$urandom, $urandom});
      if (r[31:29] == 0) begin
        baseline(); issue(3, 0, ENC, 0);
      end
    end
    repeat (3) @(negedge clk);
    checks++;  // R10 every selected request answered exactly once
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R10 pending responses=%0d expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule